// File: doc/BRIEF.md
# Translation Lookaside Buffer with Miss Fill

This block turns a virtual address into a physical address. It holds a small set of page-to-frame mappings. Each entry is compared with the incoming virtual page number in parallel. On a hit, the stored frame is joined to the untouched page offset, and the result is returned one cycle after the lookup. No memory traffic is needed.

On a miss, the block issues one read of a single-level page table. The read address is a page-table base register plus four times the page number. When the read data returns, the block completes the translation and installs the mapping. The victim for the install is a free entry if one exists. Otherwise it is the least recently used entry that is not pinned. A lookup can ask for its filled entry to be pinned, and a pinned entry stays resident until reset. A flush drops every unpinned mapping. Only one miss is in flight at a time. While it is outstanding, `busy` is high and lookups are ignored.

Top module: `tlb_miss_fill`

## Requirements
- R1: A lookup accepted while `busy` is low, whose page number matches a valid entry, gives `resp_valid`=1 and `resp_hit`=1 on the next cycle. In that response, `resp_paddr` is {stored frame, address bits [OFF_W-1:0]}, and `mem_req_valid` stays low.
- R2: An accepted lookup that matches no valid entry pulses `mem_req_valid` for exactly one cycle, on the next cycle. In that cycle, `mem_req_addr` = base register + page number × 4, and `busy` rises in the same cycle.
- R3: While `busy` is high, a cycle with `mem_rsp_valid`=1 ends the miss. The frame is taken from `mem_rsp_data` bits [PFN_W-1:0] and the upper bits are ignored. On the next cycle, `resp_valid`=1, `resp_hit`=0, `resp_paddr`={frame, offset} and `busy`=0.
- R4: After a miss is filled, the next lookup of the same page hits with the fetched frame.
- R5: While `busy` is high, `lookup_valid` is ignored. It produces no response and no extra memory request.
- R6: When every entry is valid, a fill replaces the unpinned entry whose last hit or fill is the oldest.
- R7: A miss looked up with `lookup_pin`=1 installs a pinned entry, and a pinned entry is never replaced.
- R8: A one-cycle `flush` invalidates every unpinned entry and keeps every pinned one.
- R9: The base register takes `ptbr_wdata` only when `ptbr_we` and `priv_mode` are both 1. A write with `priv_mode`=0 leaves it unchanged.
- R10: After reset, `resp_valid`, `busy` and `mem_req_valid` are 0, no entry is valid, and the base register is 0.
- R11: If every entry is pinned, a miss is still translated, but nothing is installed, so a repeat lookup misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Translate request |
| lookup_vaddr | input | VA_W | Virtual address |
| lookup_pin | input | 1 | Pin the entry installed by this lookup's miss |
| resp_valid | output | 1 | Translation result valid |
| resp_hit | output | 1 | Result came from a resident entry |
| resp_paddr | output | PFN_W+OFF_W | Physical address |
| busy | output | 1 | Miss outstanding; lookups ignored |
| flush | input | 1 | Invalidate all unpinned entries |
| priv_mode | input | 1 | Privileged mode qualifier for base writes |
| ptbr_we | input | 1 | Base register write enable |
| ptbr_wdata | input | ADDR_W | New base register value |
| mem_req_valid | output | 1 | Page-table read request pulse |
| mem_req_addr | output | ADDR_W | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table read data valid |
| mem_rsp_data | input | DATA_W | Page-table entry; low PFN_W bits are the frame |

## Verification
A corrupt tag or frame shows up on the next hit, one cycle after the lookup, as a wrong `resp_paddr`. It can also show up as an unexpected memory request. A wrong recency order or a lost pin does not show up right away. It appears only at a later fill, when the evicted page comes back as a miss. The bench therefore keeps its own occupancy and recency model and replays pages many lookups later. A base register that took a user-mode write shows up in the address of the next miss request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_WAIT = 1'b1
  } walk_state_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PFN_W-1:0]   hit_pfn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_wired,
  input  logic               flush,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] wired_vec
);
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, wired_q, match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == look_vpn);
  end

  always_comb begin
    hit_idx = '0;
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_idx = IDX_W'(i);
        hit_pfn = pfn_q[i];
      end
    end
  end
  assign hit = |match;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      wired_q <= '0;
    end else begin
      if (flush) valid_q <= valid_q & wired_q;
      if (fill_en) begin
        valid_q[fill_idx] <= 1'b1;
        wired_q[fill_idx] <= fill_wired;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[fill_idx] <= fill_vpn;
      pfn_q[fill_idx] <= fill_pfn;
    end
  end

  assign valid_vec = valid_q;
  assign wired_vec = wired_q;

  // R1
  one_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // R7
  wired_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (wired_q & ~valid_q) == '0);
  // R8
  flush_keep_chk: assert property (@(posedge clk) disable iff (rst)
    flush && !fill_en |=> valid_q == $past(valid_q & wired_q));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] wired_vec,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               victim_ok
);
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] best_age;
  logic             found_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    victim_ok  = 1'b0;
    found_free = 1'b0;
    best_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_vec[i] && !found_free) begin
        found_free = 1'b1;
        victim_ok  = 1'b1;
        victim_idx = IDX_W'(i);
      end
    end
    if (!found_free) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!wired_vec[i] && (!victim_ok || age_q[i] > best_age)) begin
          victim_ok  = 1'b1;
          victim_idx = IDX_W'(i);
          best_age   = age_q[i];
        end
      end
    end
  end

  // R7
  victim_not_wired_chk: assert property (@(posedge clk) disable iff (rst)
    victim_ok |-> !wired_vec[victim_idx]);
endmodule

// File: rtl/tlb_miss_fill.sv
module tlb_miss_fill #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lookup_valid,
  input  logic [VA_W-1:0]        lookup_vaddr,
  input  logic                   lookup_pin,
  output logic                   resp_valid,
  output logic                   resp_hit,
  output logic [PFN_W+OFF_W-1:0] resp_paddr,
  output logic                   busy,
  input  logic                   flush,
  input  logic                   priv_mode,
  input  logic                   ptbr_we,
  input  logic [ADDR_W-1:0]      ptbr_wdata,
  output logic                   mem_req_valid,
  output logic [ADDR_W-1:0]      mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [DATA_W-1:0]      mem_rsp_data
);
  import tlb_pkg::*;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  walk_state_t      state_q;
  logic [ADDR_W-1:0] ptbr_q;
  logic [VPN_W-1:0] pend_vpn;
  logic [OFF_W-1:0] pend_off;
  logic             pend_pin;

  logic [VPN_W-1:0] vpn_in;
  logic [OFF_W-1:0] off_in;
  logic             accept, cam_hit, fill_en, touch_en, victim_ok;
  logic [IDX_W-1:0] hit_idx, victim_idx, touch_idx;
  logic [PFN_W-1:0] hit_pfn, rsp_pfn;
  logic [ENTRIES-1:0] valid_vec, wired_vec;
  logic             unused_rsp_bits;

  assign vpn_in  = lookup_vaddr[VA_W-1:OFF_W];
  assign off_in  = lookup_vaddr[OFF_W-1:0];
  assign accept  = lookup_valid && (state_q == WALK_IDLE);
  assign rsp_pfn = mem_rsp_data[PFN_W-1:0];
  assign unused_rsp_bits = ^mem_rsp_data[DATA_W-1:PFN_W];
  assign fill_en   = (state_q == WALK_WAIT) && mem_rsp_valid && victim_ok;
  assign touch_en  = (accept && cam_hit) || fill_en;
  assign touch_idx = fill_en ? victim_idx : hit_idx;
  assign busy      = (state_q == WALK_WAIT);

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) cam_i (
    .clk(clk), .rst(rst), .look_vpn(vpn_in),
    .hit(cam_hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn),
    .fill_en(fill_en), .fill_idx(victim_idx), .fill_vpn(pend_vpn),
    .fill_pfn(rsp_pfn), .fill_wired(pend_pin), .flush(flush),
    .valid_vec(valid_vec), .wired_vec(wired_vec)
  );

  tlb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) lru_i (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid_vec(valid_vec), .wired_vec(wired_vec),
    .victim_idx(victim_idx), .victim_ok(victim_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= WALK_IDLE;
      ptbr_q        <= '0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_paddr    <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      pend_vpn      <= '0;
      pend_off      <= '0;
      pend_pin      <= 1'b0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      if (ptbr_we && priv_mode) ptbr_q <= ptbr_wdata;
      unique case (state_q)
        WALK_IDLE: begin
          if (accept) begin
            if (cam_hit) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
              resp_paddr <= {hit_pfn, off_in};
            end else begin
              state_q       <= WALK_WAIT;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= ptbr_q + (ADDR_W'(vpn_in) << 2);
              pend_vpn      <= vpn_in;
              pend_off      <= off_in;
              pend_pin      <= lookup_pin;
            end
          end
        end
        WALK_WAIT: begin
          if (mem_rsp_valid) begin
            state_q    <= WALK_IDLE;
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_paddr <= {rsp_pfn, pend_off};
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  // R2
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy && mem_rsp_valid |=> resp_valid && !resp_hit && !busy);
  // R5
  quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !mem_rsp_valid |=> !resp_valid && !mem_req_valid);
  // R9
  user_ptbr_chk: assert property (@(posedge clk) disable iff (rst)
    ptbr_we && !priv_mode |=> ptbr_q == $past(ptbr_q));
endmodule

// File: tb/tlb_miss_fill_tb.sv
module tlb_miss_fill_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_valid = 1'b0, lookup_pin = 1'b0;
  logic [31:0] lookup_vaddr = '0;
  logic        resp_valid, resp_hit, busy, mem_req_valid;
  logic [31:0] resp_paddr, mem_req_addr;
  logic        flush = 1'b0, priv_mode = 1'b0, ptbr_we = 1'b0;
  logic [31:0] ptbr_wdata = '0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int nchecks = 0, nfails = 0;

  // reference model of occupancy and recency
  logic        mv [4];
  logic        mw [4];
  logic [19:0] mvpn [4];
  logic [19:0] mpfn [4];
  int          mst [4];
  int          tick = 0;
  logic [31:0] mptbr = '0;

  always #5 clk = ~clk;

  tlb_miss_fill dut_i (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_vaddr(lookup_vaddr),
    .lookup_pin(lookup_pin), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_paddr(resp_paddr), .busy(busy), .flush(flush), .priv_mode(priv_mode),
    .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [19:0] pt_frame(logic [31:0] a);
    return (a[21:2] * 20'd13) ^ 20'h3C5A1;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mw[i] = 0; mst[i] = 0; end
    mptbr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    // R10
    chk(!resp_valid && !busy && !mem_req_valid, "R10 reset outputs",
        {resp_valid, busy, mem_req_valid}, 0);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 4; i++) mv[i] = mv[i] & mw[i];
  endtask

  task automatic write_ptbr(logic [31:0] v, bit pr);
    @(negedge clk); ptbr_we = 1'b1; ptbr_wdata = v; priv_mode = pr;
    @(negedge clk); ptbr_we = 1'b0; priv_mode = 1'b0;
    if (pr) mptbr = v;
  endtask

  task automatic lookup(logic [31:0] va, bit pin, bit poke, string tag);
    int idx = -1;
    int lat;
    int vic;
    logic [19:0] vpn = va[31:12];
    logic [31:0] eaddr;
    logic [19:0] frm;
    for (int i = 0; i < 4; i++) if (mv[i] && mvpn[i] == vpn) idx = i;
    @(negedge clk); lookup_valid = 1'b1; lookup_vaddr = va; lookup_pin = pin;
    @(negedge clk); lookup_valid = 1'b0; lookup_pin = 1'b0;
    if (idx >= 0) begin
      chk(resp_valid && resp_hit && !mem_req_valid, {tag, " R1 hit"},
          {resp_valid, resp_hit, mem_req_valid}, 3'b110);
      chk(resp_paddr == {mpfn[idx], va[11:0]}, {tag, " R1 paddr"},
          resp_paddr, {mpfn[idx], va[11:0]});
      tick++; mst[idx] = tick;
    end else begin
      eaddr = mptbr + {10'd0, vpn, 2'b00};
      chk(mem_req_valid && busy && !resp_valid, {tag, " R2 miss"},
          {mem_req_valid, busy, resp_valid}, 3'b110);
      chk(mem_req_addr == eaddr, {tag, " R2 addr"}, mem_req_addr, eaddr);
      lat = poke ? $urandom_range(1, 3) : $urandom_range(0, 3);
      for (int k = 0; k < lat; k++) begin
        if (poke && k == 0) begin lookup_valid = 1'b1; lookup_vaddr = va ^ 32'h00ABC000; end
        @(negedge clk); lookup_valid = 1'b0;
        chk(!resp_valid && !mem_req_valid && busy, {tag, " R5 busy quiet"},
            {resp_valid, mem_req_valid, busy}, 3'b001);
      end
      frm = pt_frame(eaddr);
      mem_rsp_valid = 1'b1;
      mem_rsp_data = {12'($urandom), frm};
      @(negedge clk); mem_rsp_valid = 1'b0;
      chk(resp_valid && !resp_hit && !busy, {tag, " R3 fill resp"},
          {resp_valid, resp_hit, busy}, 3'b100);
      chk(resp_paddr == {frm, va[11:0]}, {tag, " R3 paddr"}, resp_paddr, {frm, va[11:0]});
      vic = -1;
      for (int i = 0; i < 4; i++) if (!mv[i] && vic < 0) vic = i;
      if (vic < 0)
        for (int i = 0; i < 4; i++)
          if (!mw[i] && (vic < 0 || mst[i] < mst[vic])) vic = i;
      if (vic >= 0) begin
        tick++;
        mv[vic] = 1; mw[vic] = pin; mvpn[vic] = vpn; mpfn[vic] = frm; mst[vic] = tick;
      end
    end
  endtask

  function automatic bit resident(logic [19:0] vpn);
    for (int i = 0; i < 4; i++) if (mv[i] && mvpn[i] == vpn) return 1;
    return 0;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nfails++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    do_reset();
    // R10: base register is zero, so the address is page*4
    lookup(32'h0000_5123, 0, 0, "R10 first miss");
    // R4
    lookup(32'h0000_5FFF, 0, 0, "R4 refill hit");
    chk(resident(20'h5), "R4 resident", 0, 1);
    write_ptbr(32'h0010_0000, 1);
    lookup(32'h0000_7010, 0, 0, "R9 priv base");
    write_ptbr(32'h0020_0000, 0);
    lookup(32'h0000_8020, 0, 0, "R9 user write ignored");
    lookup(32'h0000_9000, 0, 0, "R6 fill last");
    lookup(32'h0000_5004, 0, 0, "R6 touch");
    lookup(32'h0000_A000, 0, 0, "R6 evict");
    // R6: page 7 was least recent, so it must miss now
    chk(!resident(20'h7), "R6 model victim", 1, 0);
    lookup(32'h0000_7444, 0, 0, "R6 evicted page");
    // R7
    lookup(32'h0002_0ABC, 1, 0, "R7 pin");
    for (int p = 0; p < 6; p++) lookup({12'h0, 8'h40 + 8'(p), 12'h0}, 0, 0, "R7 churn");
    lookup(32'h0002_0001, 0, 0, "R7 pinned hit");
    // R8
    do_flush();
    lookup(32'h0000_4500, 0, 0, "R8 flushed miss");
    lookup(32'h0002_0002, 0, 0, "R8 pinned kept");
    // R5
    lookup(32'h0000_6000, 0, 1, "R5 poke");
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 4) do_flush();
      else if (r < 7) write_ptbr({$urandom_range(0, 255), 20'h0}, 1'($urandom_range(0, 1)));
      else lookup({12'h0, 20'($urandom_range(0, 11)), 12'($urandom)}, 0,
                  1'($urandom_range(0, 4) == 0), "RND");
    end
    // R11
    do_reset();
    for (int p = 0; p < 4; p++) lookup({12'h0, 8'h80 + 8'(p), 12'h0}, 1, 0, "R11 pin all");
    lookup(32'h000C_0010, 0, 0, "R11 no room");
    lookup(32'h000C_0020, 0, 0, "R11 miss again");
    lookup(32'h0008_2030, 0, 0, "R11 pinned hit");
    finish_run();
  end
endmodule